// File: doc/BRIEF.md
# Rail-Synchronized Dual-Rail XOR Stage

This block is a clock-sampled model of one stage of a self-timed pipeline. Two words arrive on dual-rail channels. Each bit of a word is carried on two wires. The stage forms their bitwise XOR using state-holding Muller (C-element) gates. It then stores the result in a four-phase half-buffer. Every storage element is modelled as a register that rises only when all of its inputs are high, falls only when all of them are low, and otherwise keeps its value.

The bits of one word are rail-synchronized: no bit of the output may capture data while any other bit of the word is still a spacer. All upstream acknowledges therefore rise in the same cycle. A fault that drives a second rail of a bit high can leave the illegal code 11 in the output register. A sticky flag records that event so that surrounding logic can react to it.

The stage is meant to sit between a four-phase producer and a four-phase consumer. The producer drives `a_rails`/`b_rails` and watches `in_ack`. The consumer reads `out_rails` and answers on `out_ack`.

Top module: `rs_xor_stage`

## Requirements
- R1: Bit i of every channel uses rails [2i+1:2i] as {rail1, rail0}. 00 is a spacer, 01 is logic 0, 10 is logic 1 and 11 is illegal.
- R2: Valid words are driven on both inputs while `out_ack` is low. Two clock edges later, `out_rails` carries the dual-rail code of A XOR B for every bit.
- R3: A stored output rail changes only when all of its Muller inputs agree. It holds when only some bits of the input word return to spacer, even with `out_ack` high.
- R4: `in_ack[i]` is high exactly while output bit i holds a non-spacer code. It returns low after the stored word goes back to spacer.
- R5: A new valid word is captured only while `out_ack` is low. Captured data appears one edge after `out_ack` falls if the computed value is already present.
- R6: A stored word returns to spacer only while `out_ack` is high. With `out_ack` low, spacer inputs leave the output unchanged.
- R7: No output bit captures data while any other bit of the word is a spacer. All bits of `in_ack` rise in the same cycle.
- R8: When any output bit holds 11, `code_err` goes high on the following clock edge.
- R9: Once high, `code_err` stays high until reset, even after the output returns to legal codes.
- R10: A synchronous active-high `rst` clears all rails, all acknowledges and `code_err` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rails | input | 2*N_BITS | Dual-rail operand A |
| b_rails | input | 2*N_BITS | Dual-rail operand B |
| in_ack | output | N_BITS | Per-bit acknowledge to the producer |
| out_rails | output | 2*N_BITS | Stored dual-rail XOR result |
| out_ack | input | 1 | Acknowledge from the consumer |
| code_err | output | 1 | Sticky flag for an illegal 11 code on the output |

## Verification
A vector table drives six operand pairs. Between them, the pairs give every bit position all four combinations of logic values. A wrong rail pairing in the XOR cells therefore shows up as a swapped or doubled output rail rather than hiding behind a symmetric case.

Directed sequences then separate the ordering rules from one another:
- A word with one spacer bit tells rail synchronization apart from plain per-bit latching.
- Data presented while `out_ack` is high, and spacers presented while it is low, tell the bubble rule apart from the spacer rule.
- A partial return to spacer tells Muller hold behaviour apart from a simple enable.
- A forced second rail on one operand bit produces the illegal code. This checks both the one-edge delay of the flag and that the flag stays set after the output is cleared.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    DR_NULL = 2'b00,
    DR_ZERO = 2'b01,
    DR_ONE  = 2'b10,
    DR_BAD  = 2'b11
  } dr_code_e;
endpackage

// File: rtl/rs_muller.sv
module rs_muller #(
  parameter int   NIN  = 2,
  parameter logic INIT = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] in_v,
  output logic           q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= INIT;
    else if (&in_v)     q <= 1'b1;
    else if (~|in_v)    q <= 1'b0;
  end

  // R3: with disagreeing inputs the element keeps its state
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((|in_v) && !(&in_v)) |=> (q == $past(q)));
endmodule

// File: rtl/rs_xor_cell.sv
module rs_xor_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] o
);
  logic [1:0] pair [4];
  logic [3:0] m;

  assign pair[0] = {a[0], b[0]};
  assign pair[1] = {a[1], b[1]};
  assign pair[2] = {a[0], b[1]};
  assign pair[3] = {a[1], b[0]};

  for (genvar k = 0; k < 4; k++) begin : g_mc
    rs_muller #(.NIN(2), .INIT(1'b0)) u_mc (
      .clk (clk),
      .rst (rst),
      .in_v(pair[k]),
      .q   (m[k])
    );
  end

  assign o[0] = m[0] | m[1];
  assign o[1] = m[2] | m[3];
endmodule

// File: rtl/rs_half_buffer.sv
module rs_half_buffer #(
  parameter int N_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*N_BITS-1:0] comp,
  input  logic                out_ack,
  output logic [2*N_BITS-1:0] rails,
  output logic [N_BITS-1:0]   ack
);
  logic [N_BITS-1:0] valid;

  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    logic [N_BITS-1:0] others_v;
    logic              sync_ok;

    assign valid[i]  = comp[2*i] | comp[2*i+1];
    assign others_v  = valid | (N_BITS'(1) << i);
    assign sync_ok   = &others_v;

    for (genvar r = 0; r < 2; r++) begin : g_rail
      rs_muller #(.NIN(3), .INIT(1'b0)) u_mr (
        .clk (clk),
        .rst (rst),
        .in_v({comp[2*i+r], sync_ok, ~out_ack}),
        .q   (rails[2*i+r])
      );
    end

    assign ack[i] = rails[2*i] | rails[2*i+1];
  end

  // R7: acknowledges leave the empty state only all together
  assert_rise_together_R7: assert property (@(posedge clk) disable iff (rst)
    (ack == '0) |=> ((ack == '0) || (&ack)));

  // R5: no capture while the consumer still acknowledges
  assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    ((ack == '0) && out_ack) |=> (ack == '0));

  // R6: no return to spacer before the consumer acknowledges
  assert_spacer_R6: assert property (@(posedge clk) disable iff (rst)
    (!out_ack) |=> ((ack & $past(ack)) == $past(ack)));
endmodule

// File: rtl/rs_code_alarm.sv
module rs_code_alarm
  import rs_pkg::*;
#(
  parameter int N_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*N_BITS-1:0] rails,
  output logic                flag
);
  logic [N_BITS-1:0] bad;

  for (genvar i = 0; i < N_BITS; i++) begin : g_chk
    assign bad[i] = (rails[2*i +: 2] == DR_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag | (|bad);
  end

  // R8: an illegal code raises the flag one edge later
  assert_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (|bad) |=> flag);

  // R9: the flag only clears through reset
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);
endmodule

// File: rtl/rs_xor_stage.sv
module rs_xor_stage #(
  parameter int N_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*N_BITS-1:0] a_rails,
  input  logic [2*N_BITS-1:0] b_rails,
  output logic [N_BITS-1:0]   in_ack,
  output logic [2*N_BITS-1:0] out_rails,
  input  logic                out_ack,
  output logic                code_err
);
  localparam int W = 2 * N_BITS;

  logic [W-1:0] comp;

  for (genvar i = 0; i < N_BITS; i++) begin : g_xor
    rs_xor_cell u_cell (
      .clk(clk),
      .rst(rst),
      .a  (a_rails[2*i +: 2]),
      .b  (b_rails[2*i +: 2]),
      .o  (comp[2*i +: 2])
    );
  end

  rs_half_buffer #(.N_BITS(N_BITS)) u_hb (
    .clk    (clk),
    .rst    (rst),
    .comp   (comp),
    .out_ack(out_ack),
    .rails  (out_rails),
    .ack    (in_ack)
  );

  rs_code_alarm #(.N_BITS(N_BITS)) u_alarm (
    .clk  (clk),
    .rst  (rst),
    .rails(out_rails),
    .flag (code_err)
  );

  // R10: reset leaves everything empty and quiet
  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> ((out_rails == '0) && (code_err == 1'b0)));
endmodule

// File: tb/rs_xor_stage_tb.sv
`timescale 1ns/1ps
module rs_xor_stage_tb;
  import rs_pkg::*;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2*N-1:0] a_r = '0;
  logic [2*N-1:0] b_r = '0;
  logic [N-1:0] in_ack;
  logic [2*N-1:0] out_rails;
  logic         out_ack = 1'b0;
  logic         code_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rs_xor_stage #(.N_BITS(N)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .a_rails  (a_r),
    .b_rails  (b_r),
    .in_ack   (in_ack),
    .out_rails(out_rails),
    .out_ack  (out_ack),
    .code_err (code_err)
  );

  // {a, b, expected a^b} in logic values
  localparam logic [5:0] VEC [6] = '{
    6'b00_00_00, 6'b01_10_11, 6'b10_10_00,
    6'b11_01_10, 6'b01_01_00, 6'b10_11_01
  };

  function automatic logic [3:0] enc(input logic [1:0] w);
    enc = {(w[1] ? DR_ONE : DR_ZERO), (w[0] ? DR_ONE : DR_ZERO)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    step(3);
    // R10: reset state
    chk("R10 rails", 8'(out_rails), 8'h0);
    chk("R10 ack", 8'(in_ack), 8'h0);
    chk("R10 err", 8'(code_err), 8'h0);
    rst = 1'b0;
    step(1);

    // R1 R2 R4: vector table
    for (int v = 0; v < 6; v++) begin
      a_r = enc(VEC[v][5:4]);
      b_r = enc(VEC[v][3:2]);
      out_ack = 1'b0;
      step(2);
      chk("R2 xor", 8'(out_rails), 8'(enc(VEC[v][1:0])));
      chk("R4 ack up", 8'(in_ack), 8'h3);
      out_ack = 1'b1;
      a_r = '0;
      b_r = '0;
      step(2);
      chk("R4 ack down", 8'(in_ack), 8'h0);
      out_ack = 1'b0;
      step(1);
    end
    chk("R8 clean", 8'(code_err), 8'h0);

    // R7: one bit still spacer -> nothing latches
    a_r = {DR_NULL, DR_ZERO};
    b_r = {DR_NULL, DR_ONE};
    step(4);
    chk("R7 partial rails", 8'(out_rails), 8'h0);
    chk("R7 partial ack", 8'(in_ack), 8'h0);
    a_r = {DR_ONE, DR_ZERO};
    b_r = {DR_ONE, DR_ONE};
    step(2);
    chk("R7 complete", 8'(out_rails), 8'(enc(2'b01)));
    chk("R7 acks", 8'(in_ack), 8'h3);

    // R3: only bit 0 returns to spacer -> hold
    out_ack = 1'b1;
    a_r = {DR_ONE, DR_NULL};
    b_r = {DR_ONE, DR_NULL};
    step(4);
    chk("R3 hold", 8'(out_rails), 8'(enc(2'b01)));
    a_r = '0;
    b_r = '0;
    step(2);
    chk("R3 release", 8'(out_rails), 8'h0);

    // R5: data waits for the bubble
    a_r = enc(2'b11);
    b_r = enc(2'b00);
    step(4);
    chk("R5 blocked", 8'(out_rails), 8'h0);
    out_ack = 1'b0;
    step(1);
    chk("R5 accept", 8'(out_rails), 8'(enc(2'b11)));

    // R6: spacer waits for the acknowledge
    a_r = '0;
    b_r = '0;
    step(4);
    chk("R6 blocked", 8'(out_rails), 8'(enc(2'b11)));
    out_ack = 1'b1;
    step(1);
    chk("R6 accept", 8'(out_rails), 8'h0);
    chk("R4 ack low", 8'(in_ack), 8'h0);
    out_ack = 1'b0;
    step(1);

    // R8: forced second rail on A bit 0
    a_r = {DR_ZERO, DR_BAD};
    b_r = {DR_ONE, DR_ZERO};
    step(2);
    chk("R8 stored 11", 8'(out_rails), 8'({DR_ONE, DR_BAD}));
    chk("R8 not yet", 8'(code_err), 8'h0);
    step(1);
    chk("R8 flag", 8'(code_err), 8'h1);

    // R9: sticky after clearing
    out_ack = 1'b1;
    a_r = '0;
    b_r = '0;
    step(3);
    chk("R9 rails clear", 8'(out_rails), 8'h0);
    chk("R9 sticky", 8'(code_err), 8'h1);
    out_ack = 1'b0;

    // R10: reset while data is present
    a_r = enc(2'b10);
    b_r = enc(2'b00);
    rst = 1'b1;
    step(2);
    chk("R10 err clr", 8'(code_err), 8'h0);
    chk("R10 rails clr", 8'(out_rails), 8'h0);
    chk("R10 ack clr", 8'(in_ack), 8'h0);
    rst = 1'b0;
    step(2);
    chk("R2 after reset", 8'(out_rails), 8'(enc(2'b10)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule